// File: doc/BRIEF.md
# Subroutine Return-Context Stack

This block keeps the return context for nested subroutine calls in a processor that interprets Basic directly. Each call pushes one entry that joins the caller's 16-bit line number with its 16-bit statement pointer. Because both values are saved together, a return can resume at the caller at once, with no scan of program memory to find the line again. The stack holds eight such entries, last in, first out.

The top entry is always visible on two registered ports. The line number comes out on one port and the statement pointer on the other. The microcode reads the two halves in whichever cycles suit it and then issues the pop. Requests are honoured only while the processor is in run mode.

Improper use is reported on two one-cycle error pulses, and the stack is left unchanged. A stack error means a push while full or a pop while empty. An internal error means a request in command mode, or a push and a pop in the same cycle. A synchronous clear empties the stack when the processor enters run mode.

Top module: `ret_ctx_stack`

## Requirements
- R1: After reset, `depth` is 0, `is_empty` is 1, `is_full` is 0, both top ports read 0, and both error pulses are 0.
- R2: A push in run mode while not full raises `depth` by one one cycle later. From that cycle, `top_line` shows the pushed `cur_line` and `top_ptr` shows the pushed `cur_ptr`.
- R3: A pop in run mode while not empty lowers `depth` by one one cycle later. The top ports then show the entry pushed just before the removed one, with line number and pointer kept as a pair, or 0 when the stack becomes empty.
- R4: A push while `depth` is 8 writes nothing. It pulses `stk_err` high for exactly one cycle, one cycle later, and leaves `depth` and the top ports unchanged.
- R5: A pop while empty pulses `stk_err` for one cycle, one cycle later, and leaves `depth` at 0.
- R6: With `run_mode` low, any push or pop request changes nothing and pulses `int_err` for one cycle, one cycle later.
- R7: A push and a pop requested in the same cycle change nothing and pulse `int_err` for one cycle, one cycle later.
- R8: In any cycle with no accepted push, pop or clear, the top ports, `depth` and the status flags keep their values.
- R9: `clr` empties the stack one cycle later (`depth` 0, top ports 0). It takes priority over any push or pop in the same cycle and raises no error.
- R10: `is_full` is 1 exactly when `depth` is 8, and `is_empty` is 1 exactly when `depth` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 1 while the processor executes a program |
| clr | input | 1 | Synchronous clear, issued on entry to run mode |
| push_req | input | 1 | Save the current context |
| pop_req | input | 1 | Remove the top entry |
| cur_line | input | 16 | Current line number to save |
| cur_ptr | input | 16 | Current statement pointer to save |
| top_line | output | 16 | Line number half of the top entry |
| top_ptr | output | 16 | Statement pointer half of the top entry |
| depth | output | 4 | Number of entries held, 0 to 8 |
| is_empty | output | 1 | Stack holds no entry |
| is_full | output | 1 | Stack holds 8 entries |
| stk_err | output | 1 | One-cycle pulse on overflow or underflow |
| int_err | output | 1 | One-cycle pulse on a command-mode or conflicting request |

## Verification
The hardest situation to reach is a refused push at full depth, followed by a clean unwind. The stack must first be filled with eight distinct contexts. The bench then pushes once more and checks that the ninth entry neither overwrote storage nor moved the top. It does this by popping all eight entries and comparing both halves against its own LIFO model. Each line number and pointer is derived from the entry index, so any slot mix-up or half swap shows as a mismatch.

// File: rtl/ret_ctx_pkg.sv
package ret_ctx_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLEAR = 2'd3
  } stk_op_e;
endpackage

// File: rtl/ret_ctx_guard.sv
module ret_ctx_guard
  import ret_ctx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    run_mode,
  input  logic    clr,
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op,
  output logic    stk_err,
  output logic    int_err
);
  logic bad_stk, bad_int;

  always_comb begin
    op      = OP_IDLE;
    bad_stk = 1'b0;
    bad_int = 1'b0;
    if (clr) begin
      op = OP_CLEAR;
    end else if (push_req || pop_req) begin
      if (!run_mode || (push_req && pop_req)) begin
        bad_int = 1'b1;
      end else if (push_req) begin
        if (full) bad_stk = 1'b1;
        else      op = OP_PUSH;
      end else begin
        if (empty) bad_stk = 1'b1;
        else       op = OP_POP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_err <= 1'b0;
      int_err <= 1'b0;
    end else begin
      stk_err <= bad_stk;
      int_err <= bad_int;
    end
  end

  p_cmd_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_mode && !clr && (push_req || pop_req)) |=> int_err);
  p_both_req_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && push_req && pop_req) |=> (int_err && !stk_err));
  p_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (run_mode && !clr && push_req && !pop_req && full) |=> stk_err);
  p_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (run_mode && !clr && pop_req && !push_req && empty) |=> stk_err);
  p_clear_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!stk_err && !int_err));
endmodule

// File: rtl/ret_ctx_level.sv
module ret_ctx_level
  import ret_ctx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  stk_op_e          op,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  logic [LVL_W-1:0] lvl_nxt;

  always_comb begin
    case (op)
      OP_PUSH:  lvl_nxt = level + 1'b1;
      OP_POP:   lvl_nxt = level - 1'b1;
      OP_CLEAR: lvl_nxt = '0;
      default:  lvl_nxt = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      level <= lvl_nxt;
      empty <= (lvl_nxt == '0);
      full  <= (lvl_nxt == LVL_W'(DEPTH));
    end
  end

  p_push_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH) |=> (level == $past(level) + 1'b1));
  p_pop_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP) |=> (level == $past(level) - 1'b1));
  p_level_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |=> $stable(level));
  always_comb begin
    if (!rst) p_bound_r10: assert (level <= LVL_W'(DEPTH));
  end
endmodule

// File: rtl/ret_ctx_store.sv
module ret_ctx_store
  import ret_ctx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 16,
  parameter int PTR_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = LINE_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [LVL_W-1:0]  level,
  input  logic [LINE_W-1:0] line_in,
  input  logic [PTR_W-1:0]  ptr_in,
  output logic [LINE_W-1:0] top_line,
  output logic [PTR_W-1:0]  top_ptr
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] top_q;
  logic [ENT_W-1:0] new_ent;
  logic [LVL_W-1:0] below;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign new_ent = {line_in, ptr_in};
  assign wr_idx  = level[IDX_W-1:0];
  assign below   = level - LVL_W'(2);
  assign rd_idx  = below[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (op == OP_PUSH) mem[wr_idx] <= new_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
    end else begin
      case (op)
        OP_PUSH:  top_q <= new_ent;
        OP_POP:   top_q <= (level >= LVL_W'(2)) ? mem[rd_idx] : '0;
        OP_CLEAR: top_q <= '0;
        default:  top_q <= top_q;
      endcase
    end
  end

  assign top_line = top_q[ENT_W-1:PTR_W];
  assign top_ptr  = top_q[PTR_W-1:0];

  p_push_top_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH) |=> ({top_line, top_ptr} == $past(new_ent)));
  p_top_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |=> $stable({top_line, top_ptr}));
  p_clear_top_r9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLEAR) |=> ({top_line, top_ptr} == '0));
endmodule

// File: rtl/ret_ctx_stack.sv
module ret_ctx_stack
  import ret_ctx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 16,
  parameter int PTR_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_mode,
  input  logic              clr,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [LINE_W-1:0] cur_line,
  input  logic [PTR_W-1:0]  cur_ptr,
  output logic [LINE_W-1:0] top_line,
  output logic [PTR_W-1:0]  top_ptr,
  output logic [LVL_W-1:0]  depth,
  output logic              is_empty,
  output logic              is_full,
  output logic              stk_err,
  output logic              int_err
);
  stk_op_e op;

  ret_ctx_guard u_guard (
    .clk(clk), .rst(rst), .run_mode(run_mode), .clr(clr),
    .push_req(push_req), .pop_req(pop_req),
    .full(is_full), .empty(is_empty),
    .op(op), .stk_err(stk_err), .int_err(int_err)
  );

  ret_ctx_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .op(op),
    .level(depth), .empty(is_empty), .full(is_full)
  );

  ret_ctx_store #(.DEPTH(DEPTH), .LINE_W(LINE_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst(rst), .op(op), .level(depth),
    .line_in(cur_line), .ptr_in(cur_ptr),
    .top_line(top_line), .top_ptr(top_ptr)
  );

  p_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (is_full == (depth == LVL_W'(DEPTH))) && (is_empty == (depth == '0)));
  p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (is_full && push_req && !pop_req && !clr) |=> (is_full && $stable({top_line, top_ptr})));
endmodule

// File: tb/test_ret_ctx_stack.sv
module test_ret_ctx_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_mode = 1'b0, clr = 1'b0, push_req = 1'b0, pop_req = 1'b0;
  logic [15:0] cur_line = '0, cur_ptr = '0;
  logic [15:0] top_line, top_ptr;
  logic [3:0]  depth;
  logic        is_empty, is_full, stk_err, int_err;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  logic [15:0] m_line [8];
  logic [15:0] m_ptr  [8];
  int m_lvl = 0;

  ret_ctx_stack i_ret_ctx_stack (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ps, input logic pp, input logic clr_i,
                     input logic [15:0] ln, input logic [15:0] pt);
    push_req = ps; pop_req = pp; clr = clr_i; cur_line = ln; cur_ptr = pt;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0; clr = 1'b0;
  endtask

  task automatic chk_state(input string tag, input logic se, input logic ie);
    chk({tag, " depth"}, 32'(depth), 32'(m_lvl));
    chk({tag, " flags R10"}, {30'd0, is_empty, is_full}, {30'd0, m_lvl == 0, m_lvl == 8});
    chk({tag, " top"}, {top_line, top_ptr},
        (m_lvl == 0) ? 32'd0 : {m_line[m_lvl-1], m_ptr[m_lvl-1]});
    chk({tag, " errs"}, {30'd0, stk_err, int_err}, {30'd0, se, ie});
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 1'b0, 1'b0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] ln, pt;
      ln = 16'(100 + i * 10);
      pt = 16'h8000 + 16'(i * 37);
      cyc(1'b1, 1'b0, 1'b0, ln, pt);
      m_line[m_lvl] = ln; m_ptr[m_lvl] = pt; m_lvl++;
      chk_state("R2 push", 1'b0, 1'b0);
    end
  endtask

  task automatic t_overflow;
    cyc(1'b1, 1'b0, 1'b0, 16'hDEAD, 16'hBEEF);
    chk_state("R4 push full", 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    chk_state("R4 pulse ends", 1'b0, 1'b0);
  endtask

  task automatic t_unwind;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
      chk_state("R8 idle hold", 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
      m_lvl--;
      chk_state("R3 pop", 1'b0, 1'b0);
    end
  endtask

  task automatic t_underflow;
    cyc(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
    chk_state("R5 pop empty", 1'b1, 1'b0);
  endtask

  task automatic t_cmd_mode;
    cyc(1'b1, 1'b0, 1'b0, 16'd20, 16'h0200);
    m_line[0] = 16'd20; m_ptr[0] = 16'h0200; m_lvl = 1;
    run_mode = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, 16'd30, 16'h0300);
    chk_state("R6 push cmd", 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 16'h0, 16'h0);
    chk_state("R6 pop cmd", 1'b0, 1'b1);
    run_mode = 1'b1;
  endtask

  task automatic t_both;
    cyc(1'b1, 1'b1, 1'b0, 16'd40, 16'h0400);
    chk_state("R7 push+pop", 1'b0, 1'b1);
  endtask

  task automatic t_clear;
    cyc(1'b1, 1'b0, 1'b0, 16'd50, 16'h0500);
    m_line[1] = 16'd50; m_ptr[1] = 16'h0500; m_lvl = 2;
    chk_state("R2 second push", 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 16'd60, 16'h0600);
    m_lvl = 0;
    chk_state("R9 clear over push", 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 16'd70, 16'h0700);
    m_line[0] = 16'd70; m_ptr[0] = 16'h0700; m_lvl = 1;
    chk_state("R9 push after clear", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_mode = 1'b1;
    t_fill();
    t_overflow();
    t_unwind();
    t_underflow();
    t_cmd_mode();
    t_both();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule